// File: doc/BRIEF.md
# Nonvolatile Memory Write Sequencer

This block sequences write and erase operations into an on-chip nonvolatile store. Software reaches it through a small 8-bit register bus with three addresses: a control/status register, an unlock register that holds no data, and a byte-wide table latch. Table writes copy the latch into one of 64 holding bytes, picked by a 6-bit table pointer. The array reads those bytes back when it programs a whole row.

An operation is aimed at one of three places: the data EEPROM, the program memory or the configuration space. It is a write or an erase. It may start only after a two-write unlock sequence and with write permission granted. Once started, the go bit stays high for a fixed number of clock cycles set by a parameter. Only the hardware can clear it, at the end of that time. Completion raises a sticky interrupt flag.

The block has two resets. A system reset that cuts an operation short leaves an error flag set. Only the power-on reset clears that flag.

Top module: `nvm_write_ctrl`

## Requirements
- R1: Control register bit 7 selects the target. At 1 the target is program memory (`prog_target` = 1). At 0 it is data EEPROM (`prog_target` = 0).
- R2: Control bit 6 set forces the target to configuration space (`prog_target` = 2), whatever bit 7 holds.
- R3: When control bit 2 is set, a launched operation is an erase (`prog_erase` = 1). When it is clear, the operation is a write.
- R4: Control bit 1 grants write permission. It is 0 after power-on. A launch requires bit 1 = 1 in the same value that sets bit 0.
- R5: Bit 0 is the go bit. Software can set it only with a launch, and writing 0 to it does nothing. Hardware clears it when the operation ends. Writes to the control register are ignored while bit 0 is 1.
- R6: Bit 4 is the done flag, mirrored on `irq`. Hardware sets it when an operation completes. Writing 0 to bit 4 clears it. Writing 1 never sets it.
- R7: Bit 3 is the error flag, and software cannot write it. It is set when the system reset `rst_n` is low while go is 1. It is also set when go is requested without permission or without a completed unlock. It survives `rst_n`, and only `por_n` clears it.
- R8: The unlock register (address 1) always reads 0x00.
- R9: The latch (address 2) can be written and read. A `tbl_wr` strobe copies the latch into holding byte `tbl_ptr`. Holding byte `arr_idx` appears on `arr_byte`. `tbl_wr` is ignored while go is 1.
- R10: Unlock means 0x55 and then 0xAA written to address 1, with no other bus write between them. Any other bus write returns the unlock state to idle. The next control write uses up the armed state.
- R11: When a program-memory write completes, all 64 holding bytes become 0xFF. An erase, or an operation on another target, leaves them unchanged.
- R12: `prog_start` pulses for exactly one cycle after the launching edge. `prog_busy` and go stay high for exactly PROG_CYCLES cycles.
- R13: After either reset the control register reads 0x00, except for a kept error flag. The latch reads 0x00 and every holding byte reads 0xFF.
- R14: Control bit 5 always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low; clears everything |
| rst_n | input | 1 | Synchronous system reset, active low; keeps the error flag |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address: 0 control, 1 unlock, 2 latch |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Combinational read data for `bus_addr` |
| tbl_wr | input | 1 | Copy the latch into a holding byte |
| tbl_ptr | input | 6 | Holding byte index for `tbl_wr` |
| arr_idx | input | 6 | Holding byte index read by the array |
| arr_byte | output | 8 | Holding byte at `arr_idx` |
| prog_start | output | 1 | One-cycle launch pulse to the array |
| prog_busy | output | 1 | Programming timer running |
| prog_target | output | 2 | 0 data EEPROM, 1 program memory, 2 configuration |
| prog_erase | output | 1 | Launched operation is an erase |
| irq | output | 1 | Completion interrupt flag |

## Verification
The hardest case to reach is a system reset that lands while an operation is running. It must set the error flag and then keep it through further system resets until a power-on reset. The stimulus reaches it by completing an unlock, launching a data EEPROM write, and pulsing `rst_n` partway through the timer window. It then pulses `rst_n` a second time before finishing with `por_n`. A second case is an unlock sequence broken by a write in between. The register table places a latch write between 0x55 and 0xAA and then asks for go, which must be refused and must raise the error flag.

// File: rtl/nvm_pkg.sv
package nvm_pkg;
    localparam logic [1:0] A_CTRL   = 2'd0;
    localparam logic [1:0] A_UNLOCK = 2'd1;
    localparam logic [1:0] A_LATCH  = 2'd2;

    localparam int B_GO   = 0;
    localparam int B_WEN  = 1;
    localparam int B_ERS  = 2;
    localparam int B_ERR  = 3;
    localparam int B_DONE = 4;
    localparam int B_CFG  = 6;
    localparam int B_PGM  = 7;

    localparam logic [7:0] KEY_A = 8'h55;
    localparam logic [7:0] KEY_B = 8'hAA;

    typedef enum logic [1:0] {
        TGT_DATA = 2'd0,
        TGT_PROG = 2'd1,
        TGT_CFG  = 2'd2
    } target_e;

    typedef enum logic [1:0] {
        UL_IDLE  = 2'd0,
        UL_HALF  = 2'd1,
        UL_ARMED = 2'd2
    } unlock_e;
endpackage

// File: rtl/nvm_unlock_fsm.sv
module nvm_unlock_fsm
    import nvm_pkg::*;
(
    input  logic       clk,
    input  logic       por_n,
    input  logic       clr,
    input  logic       wr,
    input  logic [1:0] addr,
    input  logic [7:0] wdata,
    output logic       armed
);
    unlock_e st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d = UL_IDLE;
        end else if (wr) begin
            if (addr == A_UNLOCK && wdata == KEY_A)
                st_d = UL_HALF;
            else if (st_q == UL_HALF && addr == A_UNLOCK && wdata == KEY_B)
                st_d = UL_ARMED;
            else
                st_d = UL_IDLE;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) st_q <= UL_IDLE;
        else        st_q <= st_d;
    end

    assign armed = (st_q == UL_ARMED);
endmodule

// File: rtl/nvm_prog_timer.sv
module nvm_prog_timer #(
    parameter int PROG_CYCLES = 16
) (
    input  logic clk,
    input  logic por_n,
    input  logic abort,
    input  logic start,
    output logic busy,
    output logic done
);
    localparam int CW = (PROG_CYCLES > 2) ? $clog2(PROG_CYCLES) : 1;
    localparam logic [CW-1:0] LOAD = CW'(PROG_CYCLES - 1);

    typedef struct packed {
        logic          busy;
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t d, q;

    always_comb begin
        d = q;
        if (abort) begin
            d.busy = 1'b0;
            d.cnt  = '0;
        end else if (start && !q.busy) begin
            d.busy = 1'b1;
            d.cnt  = LOAD;
        end else if (q.busy) begin
            if (q.cnt == '0) d.busy = 1'b0;
            else             d.cnt  = q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) q <= '0;
        else        q <= d;
    end

    assign busy = q.busy;
    assign done = q.busy && (q.cnt == '0) && !abort;
endmodule

// File: rtl/nvm_hold_buf.sv
module nvm_hold_buf #(
    parameter int DEPTH = 64,
    localparam int IW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          por_n,
    input  logic          fill,
    input  logic          we,
    input  logic [IW-1:0] widx,
    input  logic [7:0]    wbyte,
    input  logic [IW-1:0] ridx,
    output logic [7:0]    rbyte
);
    logic [7:0] mem_d [DEPTH];
    logic [7:0] mem_q [DEPTH];

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            if (fill)                        mem_d[i] = 8'hFF;
            else if (we && widx == IW'(i))   mem_d[i] = wbyte;
            else                             mem_d[i] = mem_q[i];
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= 8'hFF;
        end else begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= mem_d[i];
        end
    end

    assign rbyte = mem_q[ridx];
endmodule

// File: rtl/nvm_write_ctrl.sv
module nvm_write_ctrl
    import nvm_pkg::*;
#(
    parameter int PROG_CYCLES = 16,
    parameter int HOLD_DEPTH  = 64,
    localparam int HW = $clog2(HOLD_DEPTH)
) (
    input  logic          clk,
    input  logic          por_n,
    input  logic          rst_n,
    input  logic          bus_wr,
    input  logic [1:0]    bus_addr,
    input  logic [7:0]    bus_wdata,
    output logic [7:0]    bus_rdata,
    input  logic          tbl_wr,
    input  logic [HW-1:0] tbl_ptr,
    input  logic [HW-1:0] arr_idx,
    output logic [7:0]    arr_byte,
    output logic          prog_start,
    output logic          prog_busy,
    output logic [1:0]    prog_target,
    output logic          prog_erase,
    output logic          irq
);
    typedef struct packed {
        logic       pgm;
        logic       cfg;
        logic       ers;
        logic       wen;
        logic       done;
        logic       err;
        logic       start;
        logic [7:0] latch;
    } ctl_t;

    ctl_t d, q;

    logic armed, busy, tmr_done, launch, bad_go, ctrl_wr, fill;
    logic [1:0] tgt;

    assign ctrl_wr = bus_wr && (bus_addr == A_CTRL) && !busy && rst_n;
    assign launch  = ctrl_wr && bus_wdata[B_GO] && bus_wdata[B_WEN] && armed;
    assign bad_go  = ctrl_wr && bus_wdata[B_GO] && !(bus_wdata[B_WEN] && armed);
    assign tgt     = q.cfg ? TGT_CFG : (q.pgm ? TGT_PROG : TGT_DATA);
    assign fill    = !rst_n || (tmr_done && tgt == TGT_PROG && !q.ers);

    nvm_unlock_fsm u_unlock (
        .clk   (clk),
        .por_n (por_n),
        .clr   (!rst_n),
        .wr    (bus_wr),
        .addr  (bus_addr),
        .wdata (bus_wdata),
        .armed (armed)
    );

    nvm_prog_timer #(.PROG_CYCLES(PROG_CYCLES)) u_timer (
        .clk   (clk),
        .por_n (por_n),
        .abort (!rst_n),
        .start (launch),
        .busy  (busy),
        .done  (tmr_done)
    );

    nvm_hold_buf #(.DEPTH(HOLD_DEPTH)) u_hold (
        .clk   (clk),
        .por_n (por_n),
        .fill  (fill),
        .we    (tbl_wr && !busy && rst_n),
        .widx  (tbl_ptr),
        .wbyte (q.latch),
        .ridx  (arr_idx),
        .rbyte (arr_byte)
    );

    always_comb begin
        d = q;
        d.start = launch;
        if (!rst_n) begin
            d       = '0;
            d.err   = q.err || busy;
        end else begin
            if (ctrl_wr) begin
                d.pgm  = bus_wdata[B_PGM];
                d.cfg  = bus_wdata[B_CFG];
                d.ers  = bus_wdata[B_ERS];
                d.wen  = bus_wdata[B_WEN];
                d.done = q.done && bus_wdata[B_DONE];
            end
            if (bad_go)   d.err  = 1'b1;
            if (tmr_done) d.done = 1'b1;
            if (bus_wr && bus_addr == A_LATCH) d.latch = bus_wdata;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        case (bus_addr)
            A_CTRL:  bus_rdata = {q.pgm, q.cfg, 1'b0, q.done, q.err, q.ers, q.wen, busy};
            A_LATCH: bus_rdata = q.latch;
            default: bus_rdata = 8'h00;
        endcase
    end

    assign prog_start  = q.start;
    assign prog_busy   = busy;
    assign prog_target = tgt;
    assign prog_erase  = q.ers;
    assign irq         = q.done;
endmodule

// File: rtl/nvm_write_ctrl_chk.sv
module nvm_write_ctrl_chk (
    input logic       clk,
    input logic       por_n,
    input logic       rst_n,
    input logic       bus_wr,
    input logic [1:0] bus_addr,
    input logic [7:0] bus_wdata,
    input logic [7:0] bus_rdata,
    input logic       prog_start,
    input logic       prog_busy,
    input logic       irq,
    input logic       armed,
    input logic       tmr_done,
    input logic       err_q
);
    p_go_hw_clear_r5: assert property (@(posedge clk) disable iff (!por_n)
        $fell(prog_busy) |-> ($past(!rst_n) || $past(tmr_done)));

    p_start_unlocked_r10: assert property (@(posedge clk) disable iff (!por_n)
        prog_start |-> ($past(armed) && $past(bus_wr) && $past(bus_wdata[1])));

    p_start_pulse_r12: assert property (@(posedge clk) disable iff (!por_n)
        prog_start |=> !prog_start);

    p_done_sets_flag_r6: assert property (@(posedge clk) disable iff (!por_n)
        (tmr_done && rst_n) |=> irq);

    p_flag_sticky_r6: assert property (@(posedge clk) disable iff (!por_n)
        (irq && rst_n && !(bus_wr && bus_addr == 2'd0 && !bus_wdata[4])) |=> irq);

    p_err_sticky_r7: assert property (@(posedge clk) disable iff (!por_n)
        err_q |=> err_q);

    p_reset_in_flight_r7: assert property (@(posedge clk) disable iff (!por_n)
        (!rst_n && prog_busy) |=> err_q);

    p_unlock_reads_zero_r8: assert property (@(posedge clk) disable iff (!por_n)
        (bus_addr == 2'd1) |-> (bus_rdata == 8'h00));
endmodule

bind nvm_write_ctrl nvm_write_ctrl_chk u_chk (
    .clk       (clk),
    .por_n     (por_n),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .prog_start(prog_start),
    .prog_busy (prog_busy),
    .irq       (irq),
    .armed     (armed),
    .tmr_done  (tmr_done),
    .err_q     (q.err)
);

// File: tb/nvm_write_ctrl_bench.sv
module nvm_write_ctrl_bench;
    localparam int P = 8;

    logic       clk = 1'b0;
    logic       por_n = 1'b0;
    logic       rst_n = 1'b1;
    logic       bus_wr = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       tbl_wr = 1'b0;
    logic [5:0] tbl_ptr = 6'd0;
    logic [5:0] arr_idx = 6'd0;
    logic [7:0] arr_byte;
    logic       prog_start, prog_busy, prog_erase, irq;
    logic [1:0] prog_target;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    nvm_write_ctrl #(.PROG_CYCLES(P)) u_nvm_write_ctrl (
        .clk(clk), .por_n(por_n), .rst_n(rst_n),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tbl_wr(tbl_wr), .tbl_ptr(tbl_ptr), .arr_idx(arr_idx), .arr_byte(arr_byte),
        .prog_start(prog_start), .prog_busy(prog_busy), .prog_target(prog_target),
        .prog_erase(prog_erase), .irq(irq)
    );

    // {addr, wdata, expected read of same address}
    localparam logic [17:0] VEC [7] = '{
        {2'd0, 8'h80, 8'h80},   // R1 program select readable
        {2'd0, 8'h46, 8'h46},   // R2/R3/R4 cfg, erase, wen
        {2'd1, 8'h55, 8'h00},   // R8 unlock reads zero
        {2'd2, 8'h3C, 8'h3C},   // R9 latch; breaks unlock (R10)
        {2'd1, 8'hAA, 8'h00},   // R8
        {2'd0, 8'h13, 8'h0A},   // R10/R7/R6 go refused, err set, flag not set
        {2'd0, 8'h00, 8'h08}    // R7 err kept, not writable
    };

    task automatic check(input string tag, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] v);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = v;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    function automatic int rd(input logic [1:0] a);
        return 0;
    endfunction

    task automatic rdchk(input string tag, input logic [1:0] a, input logic [7:0] exp);
        bus_addr = a;
        #0.5;
        check(tag, bus_rdata, exp);
    endtask

    task automatic tput(input logic [5:0] p);
        @(negedge clk);
        tbl_wr = 1'b1; tbl_ptr = p;
        @(negedge clk);
        tbl_wr = 1'b0;
    endtask

    task automatic hold(input string tag, input logic [5:0] i, input logic [7:0] exp);
        arr_idx = i;
        #0.5;
        check(tag, arr_byte, exp);
    endtask

    task automatic unlock();
        wr(2'd1, 8'h55);
        wr(2'd1, 8'hAA);
    endtask

    task automatic do_por();
        @(negedge clk); por_n = 1'b0;
        @(negedge clk); por_n = 1'b1;
    endtask

    task automatic do_rst();
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            n_run++; n_fail++;
            $display("FAIL watchdog actual=0x0 expected=0x1");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (2) @(negedge clk);
        por_n = 1'b1;
        // R13 reset state
        rdchk("R13 ctrl", 2'd0, 8'h00);
        rdchk("R13 latch", 2'd2, 8'h00);
        hold("R13 hold", 6'd17, 8'hFF);
        check("R13 busy", prog_busy, 0);

        for (int k = 0; k < 7; k++) begin
            wr(VEC[k][17:16], VEC[k][15:8]);
            rdchk($sformatf("R1-table v%0d", k), VEC[k][17:16], VEC[k][7:0]);
        end
        check("R7 no launch R10", prog_busy, 0);
        do_por();
        rdchk("R7 por clears", 2'd0, 8'h00);

        // R9 table writes
        wr(2'd2, 8'hA5); tput(6'd5);
        wr(2'd2, 8'h5A); tput(6'd63);
        hold("R9 idx5", 6'd5, 8'hA5);
        hold("R9 idx63", 6'd63, 8'h5A);

        // program write launch
        wr(2'd0, 8'h82);
        unlock();
        wr(2'd0, 8'h83);
        check("R12 start", prog_start, 1);
        check("R1 target prog", prog_target, 1);
        check("R3 write", prog_erase, 0);
        rdchk("R5 go set", 2'd0, 8'h83);
        wr(2'd0, 8'h02);                 // consumes one more cycle
        rdchk("R5 write ignored busy", 2'd0, 8'h83);
        check("R12 one pulse", prog_start, 0);
        repeat (P - 3) @(negedge clk);
        check("R12 still busy", prog_busy, 1);
        @(negedge clk);
        check("R12 busy ends", prog_busy, 0);
        check("R6 irq", irq, 1);
        rdchk("R6 flag", 2'd0, 8'h92);
        hold("R11 cleared", 6'd5, 8'hFF);
        hold("R11 cleared 63", 6'd63, 8'hFF);
        wr(2'd0, 8'h82);
        check("R6 clear", irq, 0);

        // config erase
        wr(2'd2, 8'h77); tput(6'd7);
        wr(2'd0, 8'hC6);
        unlock();
        wr(2'd0, 8'hC7);
        check("R2 cfg target", prog_target, 2);
        check("R3 erase", prog_erase, 1);
        wr(2'd2, 8'h99); tput(6'd8);
        repeat (P) @(negedge clk);
        check("R5 cleared", prog_busy, 0);
        hold("R9 busy ignored", 6'd8, 8'hFF);
        hold("R11 erase keeps", 6'd7, 8'h77);
        rdchk("R14 bit5 zero", 2'd0, 8'hD6);

        // wen=0 with unlock
        wr(2'd0, 8'h00);
        unlock();
        wr(2'd0, 8'h01);
        check("R4 no wen", prog_busy, 0);
        rdchk("R4 err", 2'd0, 8'h08);
        do_por();

        // reset in flight on data EEPROM
        wr(2'd0, 8'h02);
        unlock();
        wr(2'd0, 8'h03);
        check("R1 data target", prog_target, 0);
        check("R12 busy data", prog_busy, 1);
        do_rst();
        check("R7 aborted", prog_busy, 0);
        rdchk("R7 err set", 2'd0, 8'h08);
        do_rst();
        rdchk("R7 survives rst", 2'd0, 8'h08);
        rdchk("R13 latch rst", 2'd2, 8'h00);
        do_por();
        rdchk("R7 por only", 2'd0, 8'h00);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule